// File: doc/BRIEF.md
# Transport Stream Packet Identifier Gate

This block sits in the capture path of an MPEG transport stream. Bytes arrive one at a time with a valid qualifier and a start-of-packet strobe. The block reads the 13-bit packet identifier (PID) from the header of each 188-byte packet. It then decides whether the whole packet goes through or is thrown away. Accepted packets leave the block packed four bytes to a 32-bit word, 47 words per packet, with a flag on the final word.

The decision comes from a bank of programmable slots. Each slot holds a PID and an enable bit. Slot 0 also carries three global controls:
- a pass-everything mode,
- a block-everything mode,
- the byte order used for packing.

A plain synchronous write port and a registered read port give access to the slots. The block decides once the third header byte is in. Because output words only leave after their fourth byte, the sync byte and the first two header bytes are gated along with the rest of the packet.

Top module: `tspf_gate`

## Requirements
- R1: After reset, every slot reads back a PID of 0x1FFF with its enable clear. Slot 0 also has block-everything set, so it reads 0x0000_3FFF and every other slot reads 0x0000_1FFF. No packet is passed in this state.
- R2: A write stores these bits of cfg_wdata into the slot selected by cfg_addr[AW-1:2], where AW is the address width:
  - the PID in bits 12:0;
  - the enable in bit 15;
  - for slot 0 only, block-everything in bit 13, byte order in bit 14 and pass-everything in bit 16.
  cfg_addr[1:0] are ignored. cfg_rdata shows the addressed slot one cycle after the address is presented, with all bits it does not store read as zero.
- R3: A packet whose PID equals the PID of an enabled slot is passed in full. It appears as 47 words, and out_last is high on the 47th word only.
- R4: A slot with its enable clear never matches, whatever PID it holds.
- R5: With pass-everything set, every packet with a valid sync byte is passed, regardless of slot contents or block-everything.
- R6: With block-everything set and pass-everything clear, no packet is passed, even one that matches an enabled slot.
- R7: With byte order 0, the first byte of each group of four goes to bits 31:24. With byte order 1, it goes to bits 7:0. The value in force when a packet's third byte is accepted applies to the whole packet.
- R8: A packet whose first byte is not 0x47 produces no output in any mode.
- R9: The PID is the low 5 bits of byte 1 followed by byte 2. The top 3 bits of byte 1 do not affect matching.
- R10: A start strobe restarts parsing and packing at byte 0 and discards any partial word. Bytes that arrive after the 188th without a new start strobe are ignored.
- R11: A passed word is presented on the output in the cycle after its fourth byte is accepted, including when idle cycles are mixed into the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_addr | input | AW | Byte address of a slot (slot index times 4) |
| cfg_wdata | input | 32 | Slot write data |
| cfg_rdata | output | 32 | Registered read of the addressed slot |
| in_valid | input | 1 | Input byte qualifier |
| in_sop | input | 1 | Marks byte 0 of a packet |
| in_byte | input | 8 | Stream byte |
| out_valid | output | 1 | Output word qualifier |
| out_word | output | 32 | Four packed packet bytes |
| out_last | output | 1 | Marks the 47th word of a passed packet |

## Verification
The bench goes after the following corner cases, each with the failure it would expose:
- **PID bit split (R9).** A gate that used all 8 bits of byte 1 would drop packets whose byte 1 carries set upper bits.
- **Header held until the decision (R3, R11).** A design that released the first three bytes before deciding would lose them or misplace them in word 0.
- **Mode precedence (R5, R6).** If block-everything were applied after pass-everything, the pass-everything sweep would go silent.
- **Restart and overrun (R10).** Broken restart handling would either carry stale bytes into the next packet's first word or emit a 48th word.
- **Bad sync with pass-everything (R8).** A gate that checked sync only for PID matches would leak these packets.
- **Stalled input (R7, R11).** Byte order and stalls are crossed, so a lane counter that advanced on idle cycles would scramble the packing.

// File: rtl/tspf_pkg.sv
package tspf_pkg;
  localparam int PID_W       = 13;
  localparam int PKT_BYTES   = 188;
  localparam int WORD_BYTES  = 4;
  localparam int WORDS_PKT   = PKT_BYTES / WORD_BYTES;
  localparam logic [7:0] SYNC_VAL = 8'h47;

  // field positions in a slot word
  localparam int F_ENABLE  = 15;
  localparam int F_PASSALL = 16;
  localparam int F_BLOCK   = 13;
  localparam int F_ORDER   = 14;

  localparam logic [PID_W-1:0] PID_FREE = 13'h1FFF;

  typedef struct packed {
    logic             en;
    logic [PID_W-1:0] pid;
  } slot_t;

  typedef struct packed {
    logic passall;
    logic block;
    logic order_le;
  } glob_t;
endpackage

// File: rtl/tspf_slot_bank.sv
module tspf_slot_bank
  import tspf_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int AW = IW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [PID_W-1:0] pid_probe,
  output logic             hit,
  output glob_t            glob
);
  logic [IW-1:0]    sel;
  logic             sel_ok;
  slot_t            slot_a [SLOTS];
  logic [SLOTS-1:0] hit_vec;

  assign sel    = cfg_addr[AW-1:2];
  assign sel_ok = (32'(sel) < SLOTS);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    slot_t slot_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_r.en  <= 1'b0;
        slot_r.pid <= PID_FREE;
      end else if (cfg_we && sel_ok && (32'(sel) == g)) begin
        slot_r.en  <= cfg_wdata[F_ENABLE];
        slot_r.pid <= cfg_wdata[PID_W-1:0];
      end
    end
    assign slot_a[g]  = slot_r;
    assign hit_vec[g] = slot_r.en && (slot_r.pid == pid_probe);
  end

  // global controls shared with slot 0
  always_ff @(posedge clk) begin
    if (rst) begin
      glob.passall  <= 1'b0;
      glob.block    <= 1'b1;
      glob.order_le <= 1'b0;
    end else if (cfg_we && (sel == '0)) begin
      glob.passall  <= cfg_wdata[F_PASSALL];
      glob.block    <= cfg_wdata[F_BLOCK];
      glob.order_le <= cfg_wdata[F_ORDER];
    end
  end

  assign hit = |hit_vec;

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (sel_ok) begin
      rd_next[PID_W-1:0] = slot_a[sel].pid;
      rd_next[F_ENABLE]  = slot_a[sel].en;
      if (sel == '0) begin
        rd_next[F_PASSALL] = glob.passall;
        rd_next[F_BLOCK]   = glob.block;
        rd_next[F_ORDER]   = glob.order_le;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_next;
  end
endmodule

// File: rtl/tspf_hdr_parse.sv
module tspf_hdr_parse
  import tspf_pkg::*;
#(
  parameter int PKT_LEN = PKT_BYTES,
  localparam int CW = $clog2(PKT_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_byte,
  input  logic             hit,
  input  glob_t            glob,
  output logic [PID_W-1:0] pid_probe,
  output logic             acc,
  output logic [CW-1:0]    idx_cur,
  output logic             pass_q,
  output logic             order_q
);
  logic [CW-1:0] cnt;
  logic          sync_ok;
  logic [4:0]    pid_hi;
  logic          decide;

  assign idx_cur   = in_sop ? '0 : cnt;
  assign acc       = in_valid && (in_sop || (cnt < CW'(PKT_LEN)));
  assign pid_probe = {pid_hi, in_byte};
  assign decide    = acc && (idx_cur == CW'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= CW'(PKT_LEN);
      sync_ok <= 1'b0;
      pid_hi  <= '0;
      pass_q  <= 1'b0;
      order_q <= 1'b0;
    end else if (acc) begin
      cnt <= idx_cur + CW'(1);
      if (idx_cur == '0) begin
        sync_ok <= (in_byte == SYNC_VAL);
        pass_q  <= 1'b0;
      end
      if (idx_cur == CW'(1)) pid_hi <= in_byte[4:0];
      if (decide) begin
        pass_q  <= sync_ok && (glob.passall || (!glob.block && hit));
        order_q <= glob.order_le;
      end
    end
  end
endmodule

// File: rtl/tspf_packer.sv
module tspf_packer
  import tspf_pkg::*;
#(
  parameter int PKT_LEN = PKT_BYTES,
  localparam int CW = $clog2(PKT_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic [CW-1:0] idx_cur,
  input  logic [7:0]    in_byte,
  input  logic          pass_q,
  input  logic          order_q,
  output logic          out_valid,
  output logic [31:0]   out_word,
  output logic          out_last
);
  logic [7:0] lane_q [WORD_BYTES-1];
  logic [1:0] lane;
  logic [7:0] grp [WORD_BYTES];
  logic [31:0] w_be, w_le;

  assign lane = idx_cur[1:0];

  for (genvar g = 0; g < WORD_BYTES - 1; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst)                              lane_q[g] <= '0;
      else if (acc && (lane == 2'(g)))      lane_q[g] <= in_byte;
    end
    assign grp[g] = lane_q[g];
  end
  assign grp[WORD_BYTES-1] = in_byte;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_pack
    assign w_be[31-8*g -: 8] = grp[g];
    assign w_le[8*g+7  -: 8] = grp[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (acc && (lane == 2'(WORD_BYTES - 1)) && pass_q) begin
        out_valid <= 1'b1;
        out_last  <= (idx_cur == CW'(PKT_LEN - 1));
        out_word  <= order_q ? w_le : w_be;
      end
    end
  end
endmodule

// File: rtl/tspf_gate.sv
module tspf_gate
  import tspf_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int AW = IW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [7:0]    in_byte,
  output logic          out_valid,
  output logic [31:0]   out_word,
  output logic          out_last
);
  localparam int CW = $clog2(PKT_BYTES + 1);

  logic [PID_W-1:0] pid_probe;
  logic             hit;
  glob_t            glob;
  logic             acc;
  logic [CW-1:0]    idx_cur;
  logic             pass_q;
  logic             order_q;

  tspf_slot_bank #(.SLOTS(SLOTS)) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pid_probe(pid_probe), .hit(hit), .glob(glob)
  );

  tspf_hdr_parse #(.PKT_LEN(PKT_BYTES)) u_parse (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
    .in_byte(in_byte), .hit(hit), .glob(glob), .pid_probe(pid_probe),
    .acc(acc), .idx_cur(idx_cur), .pass_q(pass_q), .order_q(order_q)
  );

  tspf_packer #(.PKT_LEN(PKT_BYTES)) u_pack (
    .clk(clk), .rst(rst), .acc(acc), .idx_cur(idx_cur), .in_byte(in_byte),
    .pass_q(pass_q), .order_q(order_q), .out_valid(out_valid),
    .out_word(out_word), .out_last(out_last)
  );
endmodule

// File: rtl/tspf_gate_chk.sv
module tspf_gate_chk
  import tspf_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_sop,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic       out_last
);
  logic [7:0] wcnt;
  logic       sync_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt      <= '0;
      sync_seen <= 1'b0;
    end else begin
      if (in_valid && in_sop) begin
        wcnt      <= '0;
        sync_seen <= (in_byte == SYNC_VAL);
      end else if (out_valid) begin
        wcnt <= out_last ? 8'd0 : wcnt + 8'd1;
      end
    end
  end

  // R3
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R3
  last_on_final_word_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (wcnt == 8'(WORDS_PKT - 1)));

  // R11
  word_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R8
  sync_required_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> sync_seen);
endmodule

bind tspf_gate tspf_gate_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
  .in_byte(in_byte), .out_valid(out_valid), .out_last(out_last)
);

// File: tb/sim_tspf_gate.sv
module sim_tspf_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 8;
  localparam int AW = 5;
  localparam int NWORD = 47;
  localparam int CAPN = 128;

  logic clk = 0, rst = 1;
  logic cfg_we = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic in_valid = 0, in_sop = 0;
  logic [7:0] in_byte = '0;
  logic out_valid, out_last;
  logic [31:0] out_word;

  tspf_gate #(.SLOTS(NSLOT)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_sop(in_sop), .in_byte(in_byte), .out_valid(out_valid),
    .out_word(out_word), .out_last(out_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0, errors = 0;
  logic [31:0] shadow [NSLOT];

  logic [31:0] cap_w [CAPN];
  bit          cap_l [CAPN];
  int          cap_n = 0, first_cyc = -1;
  logic [31:0] exp_w [CAPN];
  bit          exp_l [CAPN];
  int          exp_n = 0, b3_cyc = -1;

  always @(negedge clk) begin
    if (out_valid) begin
      if (cap_n < CAPN) begin
        cap_w[cap_n] = out_word;
        cap_l[cap_n] = out_last;
      end
      if (cap_n == 0) first_cyc = cyc;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(int i, logic [7:0] s, logic [7:0] b1,
                                    logic [7:0] b2, int seed);
    if (i == 0) return s;
    if (i == 1) return b1;
    if (i == 2) return b2;
    return 8'((seed * 7 + i * 13) & 255);
  endfunction

  function automatic bit model_pass(logic [7:0] s, logic [7:0] b1, logic [7:0] b2);
    logic [12:0] pid;
    bit hit;
    pid = {b1[4:0], b2};
    hit = 0;
    for (int k = 0; k < NSLOT; k++)
      if (shadow[k][15] && shadow[k][12:0] == pid) hit = 1;
    if (s != 8'h47) return 0;
    if (shadow[0][16]) return 1;
    if (shadow[0][13]) return 0;
    return hit;
  endfunction

  task automatic cfg_write(int s, logic [31:0] w);
    @(negedge clk);
    cfg_we = 1; cfg_addr = AW'(s * 4); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 0;
    shadow[s] = w;
  endtask

  task automatic cfg_check(int s, string req);
    logic [31:0] e;
    e = (s == 0) ? (shadow[s] & 32'h0001_FFFF) : (shadow[s] & 32'h0000_9FFF);
    @(negedge clk);
    cfg_addr = AW'(s * 4 + (s & 3));
    @(negedge clk);
    check(cfg_rdata == e, req, cfg_rdata, e);
  endtask

  task automatic clear_cap();
    cap_n = 0; exp_n = 0; first_cyc = -1; b3_cyc = -1;
  endtask

  task automatic drive_pkt(logic [7:0] s, logic [7:0] b1, logic [7:0] b2,
                           int seed, int nb, bit gaps);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0); in_byte = pb(i, s, b1, b2, seed);
      if (i == 3 && b3_cyc < 0) b3_cyc = cyc;
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        in_valid = 0; in_sop = 0;
      end
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0;
  endtask

  task automatic expect_pkt(logic [7:0] s, logic [7:0] b1, logic [7:0] b2,
                            int seed, int nb);
    logic [31:0] w;
    if (!model_pass(s, b1, b2)) return;
    for (int k = 0; k < nb / 4; k++) begin
      for (int j = 0; j < 4; j++) begin
        if (shadow[0][14]) w[8*j +: 8] = pb(4*k + j, s, b1, b2, seed);
        else               w[24 - 8*j +: 8] = pb(4*k + j, s, b1, b2, seed);
      end
      exp_w[exp_n] = w;
      exp_l[exp_n] = (k == NWORD - 1);
      exp_n++;
    end
  endtask

  task automatic finish_check(string req);
    repeat (3) @(negedge clk);
    check(cap_n == exp_n, req, 32'(cap_n), 32'(exp_n));
    if (cap_n == exp_n) begin
      for (int k = 0; k < exp_n; k++) begin
        check(cap_w[k] == exp_w[k], req, cap_w[k], exp_w[k]);
        check(cap_l[k] == exp_l[k], req, 32'(cap_l[k]), 32'(exp_l[k]));
      end
    end
    if (exp_n > 0)
      check(first_cyc == b3_cyc + 1, {req, " R11 latency"},
            32'(first_cyc), 32'(b3_cyc + 1));
  endtask

  task automatic run_pkt(logic [7:0] s, logic [7:0] b1, logic [7:0] b2,
                         int seed, bit gaps, string req);
    clear_cap();
    expect_pkt(s, b1, b2, seed, 188);
    drive_pkt(s, b1, b2, seed, 188, gaps);
    finish_check(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [12:0] p;
    for (int k = 0; k < NSLOT; k++) shadow[k] = 32'h0000_1FFF;
    shadow[0] = 32'h0000_3FFF;
    repeat (4) @(negedge clk);
    rst = 0;
    check(out_valid == 0, "R1 out idle", 32'(out_valid), 0);

    // R1 reset contents and default blocking
    for (int k = 0; k < NSLOT; k++) cfg_check(k, "R1 reset slot");
    run_pkt(8'h47, 8'h1F, 8'hFF, 1, 0, "R1 blocked at reset");

    // R2 write/read back, unstored bits
    cfg_write(5, 32'hFFFF_FFFF); cfg_check(5, "R2 slot5 masked");
    cfg_write(0, 32'hFFFF_FFFF); cfg_check(0, "R2 slot0 masked");
    cfg_write(5, 32'h0000_1FFF); cfg_check(5, "R2 slot5 release");

    // R3 per-slot sweep
    for (int s = 0; s < NSLOT; s++) begin
      p = 13'(13'h100 * s + 13'h021);
      cfg_write(s, {16'h0000, 3'b100, p});
      cfg_check(s, "R2 slot program");
    end
    for (int s = 0; s < NSLOT; s++) begin
      p = 13'(13'h100 * s + 13'h021);
      run_pkt(8'h47, {3'b000, p[12:8]}, p[7:0], s, 0, "R3 slot hit");
      run_pkt(8'h47, {3'b000, p[12:8] ^ 5'h10}, p[7:0], s, 0, "R3 miss");
    end

    // R9 upper bits of byte 1 ignored
    run_pkt(8'h47, 8'hE3, 8'h21, 11, 0, "R9 upper bits");

    // R4 disabled slot
    cfg_write(2, 32'h0000_0221);
    run_pkt(8'h47, 8'h02, 8'h21, 12, 0, "R4 disabled");
    cfg_write(2, 32'h0000_1FFF);
    run_pkt(8'h47, 8'h1F, 8'hFF, 13, 0, "R4 released");

    // R6 block-everything beats a match
    cfg_write(0, 32'h0000_A021);
    run_pkt(8'h47, 8'h00, 8'h21, 14, 0, "R6 block");

    // R5 pass-everything overrides block
    cfg_write(0, 32'h0001_A021);
    for (int k = 0; k < 6; k++) begin
      p = 13'((k * 1531 + 77) % 8192);
      run_pkt(8'h47, {3'b010, p[12:8]}, p[7:0], 20 + k, k[0], "R5 passall");
    end

    // R8 bad sync dropped in any mode
    run_pkt(8'h46, 8'h00, 8'h21, 30, 0, "R8 bad sync passall");
    cfg_write(0, 32'h0000_8021);
    run_pkt(8'hC7, 8'h00, 8'h21, 31, 0, "R8 bad sync match");

    // R7 byte order, with and without stalls
    cfg_write(0, 32'h0000_C021);
    run_pkt(8'h47, 8'h03, 8'h21, 40, 0, "R7 little order");
    run_pkt(8'h47, 8'h03, 8'h21, 41, 1, "R7 little order stalls");
    cfg_write(0, 32'h0000_8021);
    run_pkt(8'h47, 8'h03, 8'h21, 42, 1, "R11 big order stalls");

    // R10 restart after partial packet, overrun ignored
    clear_cap();
    expect_pkt(8'h47, 8'h00, 8'h21, 50, 50);
    expect_pkt(8'h47, 8'h04, 8'h21, 51, 188);
    drive_pkt(8'h47, 8'h00, 8'h21, 50, 50, 0);
    drive_pkt(8'h47, 8'h04, 8'h21, 51, 188, 0);
    finish_check("R10 restart");
    clear_cap();
    expect_pkt(8'h47, 8'h05, 8'h21, 52, 188);
    drive_pkt(8'h47, 8'h05, 8'h21, 52, 200, 0);
    finish_check("R10 overrun");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule